// File: doc/BRIEF.md
# Host-to-controller mailbox register block

This block is a small register window that lets a host processor hand a request to a companion controller processor and collect the answer. The host first stores up to sixteen payload bytes in an outbound window, then writes one command word. That write rings a doorbell toward the controller and marks the mailbox busy. The controller reads the command and the valid part of the payload, places any answer in an inbound window, and strobes done together with an error flag and an error code. Done clears busy. If the command asked for it, the host also gets a one-cycle completion pulse, which needs no acknowledge.

The host side is a plain 32-bit register port with combinational read data. A byte-read qualifier returns one addressed byte instead of a whole word. The controller side has its own word index into both payload windows, the latched command word, and the done/error inputs. Address map: command at 0x00 (write-only), status at 0x04 (read-only), outbound payload at 0x80–0x8F (write-only), inbound payload at 0x90–0x9F (read-only from the host).

Top module: `mbox_regblk`

## Requirements
- R1: After reset, status reads as the initiator id in bits [15:8] with every other bit 0 (default id 0xA5), and h_irq and c_doorbell are low.
- R2: A command write (address 0x00) while not busy is accepted. In the next cycle status bit 0 (busy) reads 1, c_cmd shows the written word, and status bits [7:4] show command bits [15:12] (command id).
- R3: Every command write, accepted or not, gives a c_doorbell pulse of exactly one cycle in the following cycle.
- R4: Busy stays 1 until c_done is strobed. Done clears busy, loads c_err into status bit 1 and c_errcode into status bits [23:16]. A done strobe while idle changes nothing.
- R5: An accepted command clears status bit 1 and status bits [23:16].
- R6: If bit 8 of the accepted command word is 1, h_irq pulses for exactly one cycle in the cycle after done. If bit 8 is 0, no pulse occurs.
- R7: A command write while busy is ignored: c_cmd and the status command id keep their values. Status bit 2 (overrun) sets and stays set until reset.
- R8: The host writes outbound payload word i at 0x80+4*i (i = 0..3). Host reads of 0x80–0x8F and of 0x00 return 0.
- R9: The controller reads outbound word c_idx on c_wbuf_rdata. Byte lane b returns the stored byte only if 4*c_idx+b is below command bits [23:16] (size); otherwise the lane reads 0.
- R10: c_rbuf_we writes c_rbuf_wdata into inbound word c_idx, and a host word read at 0x90+4*i returns it. Host writes to 0x90–0x9F and to 0x04 have no effect.
- R11: With h_byte = 1, h_rdata returns byte h_addr[1:0] of the addressed word in bits [7:0], with bits [31:8] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_byte | input | 1 | Host read returns a single byte |
| h_rdata | output | 32 | Host read data (combinational) |
| h_irq | output | 1 | Completion pulse to the host |
| c_doorbell | output | 1 | Command-written pulse to the controller |
| c_cmd | output | 32 | Last accepted command word |
| c_idx | input | 2 | Controller word index into the payload windows |
| c_wbuf_rdata | output | 32 | Outbound payload word, masked by size |
| c_rbuf_we | input | 1 | Controller write to the inbound payload |
| c_rbuf_wdata | input | 32 | Controller inbound write data |
| c_done | input | 1 | Controller finished the command |
| c_err | input | 1 | Error flag captured at done |
| c_errcode | input | 8 | Error code captured at done |

## Verification
The bench sends a second command while the first is still busy. A design that accepted it would overwrite c_cmd and the command id, and a design that gated the doorbell on acceptance would miss the pulse. It strobes done while idle, which would corrupt the error fields or pulse h_irq if not ignored. It reads the outbound payload with a size that ends part-way through a word, where a wrong mask leaks stale bytes. It issues a command without the completion bit after one with it, which catches an interrupt tied to the wrong command, and checks that a new command wipes the previous error while the overrun flag stays set.

// File: rtl/mbox_regblk.sv
module mbox_regblk #(
  parameter logic [7:0] INIT_ID = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic [7:0]  h_addr,
  input  logic [31:0] h_wdata,
  input  logic        h_byte,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  output logic        c_doorbell,
  output logic [31:0] c_cmd,
  input  logic [1:0]  c_idx,
  output logic [31:0] c_wbuf_rdata,
  input  logic        c_rbuf_we,
  input  logic [31:0] c_rbuf_wdata,
  input  logic        c_done,
  input  logic        c_err,
  input  logic [7:0]  c_errcode
);
  localparam int WORDS = 4;

  logic        busy_q, err_q, ovr_q, db_q, irq_q;
  logic [7:0]  ecode_q;
  logic [31:0] cmd_q;
  logic [31:0] wbuf [WORDS];
  logic [31:0] rbuf [WORDS];
  logic [31:0] status, word;

  wire cmd_wr = h_wr && (h_addr[7:2] == 6'h00);
  wire accept = cmd_wr && !busy_q;
  wire fin    = c_done && busy_q;

  assign status     = {8'h00, ecode_q, INIT_ID, cmd_q[15:12], 1'b0, ovr_q, err_q, busy_q};
  assign c_cmd      = cmd_q;
  assign c_doorbell = db_q;
  assign h_irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
      db_q    <= 1'b0;
      irq_q   <= 1'b0;
      ecode_q <= 8'h00;
      cmd_q   <= 32'h0;
    end else begin
      db_q  <= cmd_wr;
      irq_q <= fin && cmd_q[8];
      if (cmd_wr && busy_q) ovr_q <= 1'b1;
      if (accept) begin
        busy_q  <= 1'b1;
        cmd_q   <= h_wdata;
        err_q   <= 1'b0;
        ecode_q <= 8'h00;
      end else if (fin) begin
        busy_q  <= 1'b0;
        err_q   <= c_err;
        ecode_q <= c_errcode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        wbuf[i] <= 32'h0;
        rbuf[i] <= 32'h0;
      end
    end else begin
      if (h_wr && h_addr[7:4] == 4'h8) wbuf[h_addr[3:2]] <= h_wdata;
      if (c_rbuf_we) rbuf[c_idx] <= c_rbuf_wdata;
    end
  end

  always_comb begin
    word = 32'h0;
    if (h_addr[7:2] == 6'h01) word = status;
    else if (h_addr[7:4] == 4'h9) word = rbuf[h_addr[3:2]];
    h_rdata = h_byte ? {24'h0, word[8*h_addr[1:0] +: 8]} : word;
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign c_wbuf_rdata[8*b +: 8] =
      ({4'h0, c_idx, 2'(b)} < cmd_q[23:16]) ? wbuf[c_idx][8*b +: 8] : 8'h00;
  end

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && cmd_q == $past(h_wdata)); // R2
  AST_DOORBELL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> c_doorbell); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !c_done |=> busy_q); // R4
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && c_done && !cmd_wr |=> !busy_q && $stable(ecode_q) && $stable(err_q)); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> $past(c_done && busy_q && cmd_q[8])); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |=> !h_irq); // R6
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy_q |=> ovr_q && $stable(cmd_q)); // R7
endmodule

// File: tb/mbox_regblk_bench.sv
module mbox_regblk_bench;
  logic        clk = 0, rst_n = 0;
  logic        h_wr = 0, h_byte = 0, c_rbuf_we = 0, c_done = 0, c_err = 0;
  logic [7:0]  h_addr = 0, c_errcode = 0;
  logic [31:0] h_wdata = 0, c_rbuf_wdata = 0;
  logic [1:0]  c_idx = 0;
  logic [31:0] h_rdata, c_cmd, c_wbuf_rdata;
  logic        h_irq, c_doorbell;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  mbox_regblk u_mbox_regblk (.*);

  always #10 clk = ~clk;

  task automatic expect_(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: samples mid-cycle, after the driver has set inputs at negedge
  always @(negedge clk) begin
    #5;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = h_rdata;
        1: act = {31'h0, c_doorbell};
        2: act = {31'h0, h_irq};
        3: act = c_wbuf_rdata;
        default: act = c_cmd;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    h_wr = 0; h_byte = 0; c_rbuf_we = 0; c_done = 0;
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    cyc(); h_wr = 1; h_addr = a; h_wdata = d;
  endtask

  task automatic hread(logic [7:0] a, bit byt, logic [31:0] exp, string req);
    h_addr = a; h_byte = byt; expect_(0, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(); hread(8'h04, 0, 32'h0000A500, "R1"); expect_(1, 0, "R1"); expect_(2, 0, "R1");
    hwrite(8'h80, 32'h44332211);
    hwrite(8'h84, 32'h88776655);
    hwrite(8'h88, 32'hCCBBAA99);
    hwrite(8'h8C, 32'h00FFEEDD);
    cyc(); hread(8'h84, 0, 0, "R8");
    cyc(); hread(8'h00, 0, 0, "R8");
    hwrite(8'h00, 32'h000631FF);
    cyc(); hread(8'h04, 0, 32'h0000A531, "R2"); expect_(1, 1, "R3"); expect_(4, 32'h000631FF, "R2");
    c_idx = 0; expect_(3, 32'h44332211, "R9");
    cyc(); expect_(1, 0, "R3"); c_idx = 1; expect_(3, 32'h00006655, "R9");
    hwrite(8'h00, 32'h0001520F);
    cyc(); expect_(1, 1, "R3"); expect_(4, 32'h000631FF, "R7"); hread(8'h04, 0, 32'h0000A535, "R7");
    c_rbuf_we = 1; c_idx = 0; c_rbuf_wdata = 32'hDEADBEEF;
    cyc(); c_rbuf_we = 1; c_idx = 2; c_rbuf_wdata = 32'h01020304;
    hwrite(8'h90, 32'h12345678);
    hwrite(8'h04, 32'hFFFFFFFF);
    cyc(); hread(8'h90, 0, 32'hDEADBEEF, "R10");
    cyc(); hread(8'h98, 0, 32'h01020304, "R10");
    cyc(); hread(8'h91, 1, 32'h000000BE, "R11");
    cyc(); hread(8'h9B, 1, 32'h00000001, "R11");
    repeat (4) cyc();
    hread(8'h04, 0, 32'h0000A535, "R4");
    cyc(); c_done = 1; c_err = 1; c_errcode = 8'h5A;
    cyc(); expect_(2, 1, "R6"); hread(8'h04, 0, 32'h005AA536, "R4");
    cyc(); expect_(2, 0, "R6");
    c_done = 1; c_err = 0; c_errcode = 8'h11;
    cyc(); hread(8'h04, 0, 32'h005AA536, "R4"); expect_(2, 0, "R4");
    hwrite(8'h00, 32'h00107010);
    cyc(); hread(8'h04, 0, 32'h0000A575, "R5"); c_idx = 3; expect_(3, 32'h00FFEEDD, "R9");
    cyc(); c_done = 1; c_err = 0; c_errcode = 8'h00;
    cyc(); expect_(2, 0, "R6"); hread(8'h04, 0, 32'h0000A574, "R7");
    cyc(); cyc();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      repeat (20000) @(posedge clk);
    join_any
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule